// File: doc/BRIEF.md
# Display Event Interrupt Register Block

This block is the interrupt front end of a display timing peripheral. Four single-cycle event strobes arrive from the timing generator: a line begins, a line ends, a frame begins and a frame ends. Each strobe latches a sticky bit in a pending register. A level interrupt is raised for as long as any pending bit is also enabled. The host services the interrupt through a small register port. It reads the pending bits, clears the ones it has handled by writing ones to them, and programs the enable mask. A host that leaves every enable at zero still sees each event in the pending register, so it can poll.

The block also holds a set of configuration words for the timing engine. The host may write these at any time, but the writes only reach a shadow copy. On each frame-begin strobe, every shadow word moves into the active copy in one step. The timing engine therefore never sees a frame that mixes old and new settings.

Top module: `vid_evt_irq`

## Requirements
- R1: Input `evt_i` carries one strobe per source, at these bit positions: bit 0 line begin, bit 1 line end, bit 2 frame begin, bit 3 frame end. A strobe sampled high on a clock edge sets the matching pending bit, which reads back from offset 0 after that edge.
- R2: `irq_o` is high exactly when at least one bit is both pending and enabled. It stays high until those bits are cleared or disabled.
- R3: A write to offset 0 clears every pending bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R4: Pending bits set whether or not they are enabled. With all enables zero, `irq_o` stays low while events still show up in the pending register.
- R5: Offset 1 holds the enable mask in data bits 3:0, using the same bit positions as R1. It is read/write, and its upper data bits read as zero.
- R6: Offsets 2 to 2+NUM_CFG-1 hold the shadow configuration words. The host may write them at any time, and reading one returns its shadow value.
- R7: The active configuration words on `cfg_active_o` (word i at bits i*CFG_W and up) take the shadow values present at a frame-begin strobe edge, and change only right after that edge. A shadow write in the same cycle as that strobe reaches the active words at the next frame begin.
- R8: If a strobe and a host clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: An event arriving while the host clears other bits sets its pending bit again, so no event is lost and the interrupt stays asserted.
- R10: Reset clears the pending, enable, shadow and active registers to zero.
- R11: Writes to offsets above the last configuration word change no register, and reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 4 | Event strobes, bit order as in R1 |
| reg_addr_i | input | ADDR_W | Register offset for read and write |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt |
| cfg_active_o | output | NUM_CFG*CFG_W | Active configuration words |

## Verification
The hardest situation to reach is a strobe and a clear landing on the same bit in the same cycle. A close second is a shadow write that coincides with a frame-begin strobe. Neither can be seen by looking at the registers one cycle at a time. The stimulus therefore drives the write strobe and the event vector from a single per-cycle task, so that both can be placed on the same edge. The pending and active values are then checked on the very next cycle. A service sequence that clears one bit while a fresh event arrives on another also shows that the interrupt never drops in between.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;

    localparam int unsigned NUM_SRC = 4;

    typedef enum logic [1:0] {
        SRC_LINE_BEG = 2'd0,
        SRC_LINE_END = 2'd1,
        SRC_FRM_BEG  = 2'd2,
        SRC_FRM_END  = 2'd3
    } src_e;

    localparam int unsigned OFS_PEND = 0;
    localparam int unsigned OFS_ENAB = 1;
    localparam int unsigned OFS_CFG0 = 2;

endpackage

// File: rtl/vid_irq_status.sv
module vid_irq_status #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               pend_wr_i,
    input  logic               en_wr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] en_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] en;
    } stat_t;

    stat_t stat_d, stat_q;

    always_comb begin
        stat_d = stat_q;
        if (pend_wr_i) begin
            stat_d.pend = stat_q.pend & ~wdata_i;
        end
        // events win over a same-cycle clear
        stat_d.pend = stat_d.pend | evt_i;
        if (en_wr_i) begin
            stat_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign pend_o = stat_q.pend;
    assign en_o   = stat_q.en;
    assign irq_o  = |(stat_q.pend & stat_q.en);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit_chk
        a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[k] |=> pend_o[k]);
        a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_wr_i && wdata_i[k] && !evt_i[k]) |=> !pend_o[k]);
        a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[k] && !(pend_wr_i && wdata_i[k])) |=> pend_o[k]);
        a_r8_evt_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_wr_i && wdata_i[k] && evt_i[k]) |=> pend_o[k]);
    end

    a_r5_en_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr_i |=> $stable(en_o));

endmodule

// File: rtl/vid_cfg_dbuf.sv
module vid_cfg_dbuf #(
    parameter int unsigned NUM_CFG = 4,
    parameter int unsigned CFG_W   = 16,
    localparam int unsigned IDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic [CFG_W-1:0]         wdata_i,
    input  logic                     commit_i,
    output logic [NUM_CFG*CFG_W-1:0] shadow_o,
    output logic [NUM_CFG*CFG_W-1:0] active_o
);

    typedef struct packed {
        logic [NUM_CFG-1:0][CFG_W-1:0] shadow;
        logic [NUM_CFG-1:0][CFG_W-1:0] active;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (wr_i && (idx_i == IDX_W'(i))) begin
                cfg_d.shadow[i] = wdata_i;
            end
        end
        // commit uses the shadow as it stood before this edge
        if (commit_i) begin
            cfg_d.active = cfg_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign shadow_o = cfg_q.shadow;
    assign active_o = cfg_q.active;

    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(active_o));
    a_r7_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (active_o == $past(shadow_o)));

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg_chk
        a_r6_shadow_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && idx_i == IDX_W'(i)) |=> (shadow_o[i*CFG_W +: CFG_W] == $past(wdata_i)));
    end

endmodule

// File: rtl/vid_reg_if.sv
module vid_reg_if #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned NUM_CFG = 4,
    parameter int unsigned CFG_W   = 16,
    localparam int unsigned IDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     wr_i,
    input  logic [NUM_SRC-1:0]       pend_i,
    input  logic [NUM_SRC-1:0]       en_i,
    input  logic [NUM_CFG*CFG_W-1:0] shadow_i,
    output logic                     pend_wr_o,
    output logic                     en_wr_o,
    output logic                     cfg_wr_o,
    output logic [IDX_W-1:0]         cfg_idx_o,
    output logic [DATA_W-1:0]        rdata_o
);

    import vid_irq_pkg::*;

    logic [ADDR_W-1:0] rel_w;
    logic              is_pend, is_enab, is_cfg;

    assign rel_w   = addr_i - ADDR_W'(OFS_CFG0);
    assign is_pend = (addr_i == ADDR_W'(OFS_PEND));
    assign is_enab = (addr_i == ADDR_W'(OFS_ENAB));
    assign is_cfg  = (addr_i >= ADDR_W'(OFS_CFG0)) && (rel_w < ADDR_W'(NUM_CFG));

    assign pend_wr_o = wr_i && is_pend;
    assign en_wr_o   = wr_i && is_enab;
    assign cfg_wr_o  = wr_i && is_cfg;
    assign cfg_idx_o = IDX_W'(rel_w);

    always_comb begin
        rdata_o = '0;
        if (is_pend) begin
            rdata_o = DATA_W'(pend_i);
        end else if (is_enab) begin
            rdata_o = DATA_W'(en_i);
        end else if (is_cfg) begin
            for (int i = 0; i < NUM_CFG; i++) begin
                if (cfg_idx_o == IDX_W'(i)) begin
                    rdata_o = DATA_W'(shadow_i[i*CFG_W +: CFG_W]);
                end
            end
        end
    end

    a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_wr_o, en_wr_o, cfg_wr_o}));

endmodule

// File: rtl/vid_evt_irq.sv
module vid_evt_irq #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_CFG = 4,
    parameter int unsigned CFG_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               evt_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic                     reg_wr_i,
    input  logic [DATA_W-1:0]        reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    output logic                     irq_o,
    output logic [NUM_CFG*CFG_W-1:0] cfg_active_o
);

    import vid_irq_pkg::*;

    localparam int unsigned IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

    logic [NUM_SRC-1:0]       pend_w, en_w;
    logic                     pend_wr_w, en_wr_w, cfg_wr_w;
    logic [IDX_W-1:0]         cfg_idx_w;
    logic [NUM_CFG*CFG_W-1:0] shadow_w;

    vid_reg_if #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
        .NUM_CFG(NUM_CFG), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr_i(reg_addr_i), .wr_i(reg_wr_i),
        .pend_i(pend_w), .en_i(en_w), .shadow_i(shadow_w),
        .pend_wr_o(pend_wr_w), .en_wr_o(en_wr_w), .cfg_wr_o(cfg_wr_w),
        .cfg_idx_o(cfg_idx_w), .rdata_o(reg_rdata_o)
    );

    vid_irq_status #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .evt_i(evt_i),
        .pend_wr_i(pend_wr_w), .en_wr_i(en_wr_w),
        .wdata_i(reg_wdata_i[NUM_SRC-1:0]),
        .pend_o(pend_w), .en_o(en_w), .irq_o(irq_o)
    );

    vid_cfg_dbuf #(.NUM_CFG(NUM_CFG), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_i(cfg_wr_w), .idx_i(cfg_idx_w),
        .wdata_i(reg_wdata_i[CFG_W-1:0]),
        .commit_i(evt_i[SRC_FRM_BEG]),
        .shadow_o(shadow_w), .active_o(cfg_active_o)
    );

    a_r4_polled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w == '0) |-> !irq_o);

endmodule

// File: tb/vid_evt_irq_bench.sv
module vid_evt_irq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 4, DATA_W = 16, NUM_CFG = 4, CFG_W = 16;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [3:0]               evt = '0;
    logic [ADDR_W-1:0]        addr = '0;
    logic                     wr = 1'b0;
    logic [DATA_W-1:0]        wdata = '0;
    logic [DATA_W-1:0]        rdata;
    logic                     irq;
    logic [NUM_CFG*CFG_W-1:0] cfg_act;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // kind: 0 read data, 1 irq, 2 active cfg word
    typedef struct {
        int          kind;
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_evt_irq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .CFG_W(CFG_W))
    u_vid_evt_irq (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq), .cfg_active_o(cfg_act)
    );

    // one cycle of stimulus, consumed by the next rising edge
    task automatic cyc(input logic w, input int a, input logic [15:0] d, input logic [3:0] e);
        @(posedge clk); #1;
        wr = w; addr = ADDR_W'(a); wdata = d; evt = e;
    endtask

    task automatic push(input int kind, input int sel, input logic [15:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        wr = 1'b0; evt = '0; addr = ADDR_W'(sel);
        it.kind = kind; it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_rd(input int a, input logic [15:0] e, input string tag);
        push(0, a, e, tag);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        push(1, 0, {15'd0, e}, tag);
    endtask

    task automatic exp_cfg(input int i, input logic [15:0] e, input string tag);
        push(2, i, e, tag);
    endtask

    // monitor: compares queued expectations away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = rdata;
                    1:       act = {15'd0, irq};
                    default: act = cfg_act[it.sel*CFG_W +: CFG_W];
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        exp_rd(0, 16'h0000, "R10 pending after reset");
        exp_rd(1, 16'h0000, "R10 enable after reset");
        exp_rd(2, 16'h0000, "R10 shadow after reset");
        exp_cfg(0, 16'h0000, "R10 active after reset");
        exp_irq(1'b0, "R10 irq after reset");

        // R1 R4: events with no enables, polled
        cyc(0, 0, 16'h0, 4'b1011);
        exp_rd(0, 16'h000B, "R1 R4 pending set while disabled");
        exp_irq(1'b0, "R4 irq low when all disabled");

        // R3: clear bits 0,1, bit 3 written 0 stays
        cyc(1, 0, 16'h0003, 4'b0000);
        exp_rd(0, 16'h0008, "R3 write-one-to-clear");

        // R5 enable register, R2 irq
        cyc(1, 1, 16'hFFF8, 4'b0000);
        exp_rd(1, 16'h0008, "R5 enable readback upper zero");
        exp_irq(1'b1, "R2 irq high enabled pending");
        cyc(1, 0, 16'h0008, 4'b0000);
        exp_irq(1'b0, "R2 irq drops after clear");
        exp_rd(0, 16'h0000, "R3 pending empty");

        // R8 event and clear on same bit, same cycle
        cyc(1, 0, 16'h0002, 4'b0010);
        exp_rd(0, 16'h0002, "R8 event wins over clear");
        exp_irq(1'b0, "R2 pending but not enabled");

        // R9 event during servicing
        cyc(1, 1, 16'h000A, 4'b0000);
        exp_irq(1'b1, "R2 irq for line end");
        cyc(0, 0, 16'h0, 4'b1000);
        cyc(1, 0, 16'h0002, 4'b0000);
        exp_rd(0, 16'h0008, "R9 new event kept after clear");
        exp_irq(1'b1, "R9 irq stays asserted");
        cyc(1, 0, 16'h0008, 4'b0000);
        exp_irq(1'b0, "R9 irq low after full service");

        // R6 R7 double buffering
        cyc(1, 2, 16'h1234, 4'b0000);
        cyc(1, 3, 16'hABCD, 4'b0000);
        exp_rd(2, 16'h1234, "R6 shadow readback word0");
        exp_rd(3, 16'hABCD, "R6 shadow readback word1");
        exp_cfg(0, 16'h0000, "R7 active unchanged before commit");
        cyc(0, 0, 16'h0, 4'b1000);
        exp_cfg(0, 16'h0000, "R7 frame end does not commit");
        cyc(0, 0, 16'h0, 4'b0100);
        exp_cfg(0, 16'h1234, "R7 commit word0");
        exp_cfg(1, 16'hABCD, "R7 commit word1");
        cyc(1, 2, 16'h5555, 4'b0100);
        exp_cfg(0, 16'h1234, "R7 same-cycle write not committed");
        exp_rd(2, 16'h5555, "R6 shadow written during commit");
        cyc(0, 0, 16'h0, 4'b0100);
        exp_cfg(0, 16'h5555, "R7 next frame commits write");

        // R11 unmapped offset
        cyc(1, 0, 16'h000F, 4'b0000);
        cyc(1, 15, 16'hFFFF, 4'b0000);
        exp_rd(15, 16'h0000, "R11 unmapped reads zero");
        exp_rd(1, 16'h000A, "R11 enable untouched");
        exp_rd(2, 16'h5555, "R11 shadow untouched");
        exp_rd(0, 16'h0000, "R11 pending untouched");
        exp_cfg(1, 16'hABCD, "R11 active untouched");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule